// File: doc/BRIEF.md
# Multiplexed Bidirectional Bus Latch

This block joins one word-wide A bus to two word-wide B banks (bank 1 and bank 2) through four independent level-sensitive holding stages. Going from B to A, each bank has its own stage, and a path-select input picks which of the two stage outputs is presented on A. Going from A to B, the A word feeds two separate stages, one per bank, so the same A bus can fill either bank on its own schedule. This is the usual way to split one time-shared address/data bus into two wide words, or to merge two banks onto one narrow bus, for example in interleaved memory.

Each stage is transparent while its enable is high. While its enable is low it shows the word it stored, which is the input value seen at the last rising clock edge at which its enable was high. Every output port has an active-low enable. A disabled port drops its drive flag and shows zero data. Each bus is split into a data-in, a data-out and a drive flag, so a pad ring can form the tristate bus. A synchronous active-high reset clears all four stored words.

Top module: `bl_mux_latch`

## Requirements
- R1: While the selected B-to-A stage has its enable high and the A port is enabled, `a_dout` equals the current input of the selected bank in the same cycle (transparent).
- R2: While a stage enable is low, that stage shows the input value sampled at the last rising clock edge at which the enable was high. It does not follow the live input.
- R3: `sel` = 1 presents the bank-1 B-to-A stage on A. `sel` = 0 presents the bank-2 stage. The stage that is not selected keeps storing under its own enable.
- R4: The A-to-B stages for bank 1 (`le_a1`) and bank 2 (`le_a2`) store independently. A change on one enable never alters the other bank's output.
- R5: While `oe_a_n` is 1, `a_drive` is 0 and `a_dout` is all zeros, whatever the other inputs are. While `oe_a_n` is 0, `a_drive` is 1.
- R6: `oe_b1_n` and `oe_b2_n` each gate only their own bank. A bank whose enable is 1 has its drive flag at 0 and zero data. Any combination of the two enables is legal.
- R7: A clock edge with `rst` high clears all four stored words to zero. A stage whose enable stays low after reset shows zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; stages sample on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | B-to-A path select: 1 = bank 1, 0 = bank 2 |
| le_b1 | input | 1 | Enable of bank-1 B-to-A stage |
| le_b2 | input | 1 | Enable of bank-2 B-to-A stage |
| le_a1 | input | 1 | Enable of A-to-bank-1 stage |
| le_a2 | input | 1 | Enable of A-to-bank-2 stage |
| oe_a_n | input | 1 | Active-low enable of the A output |
| oe_b1_n | input | 1 | Active-low enable of the bank-1 output |
| oe_b2_n | input | 1 | Active-low enable of the bank-2 output |
| a_din | input | W | A bus input |
| a_dout | output | W | A bus output data |
| a_drive | output | 1 | A bus drive flag |
| b1_din | input | W | Bank-1 input |
| b1_dout | output | W | Bank-1 output data |
| b1_drive | output | 1 | Bank-1 drive flag |
| b2_din | input | W | Bank-2 input |
| b2_dout | output | W | Bank-2 output data |
| b2_drive | output | 1 | Bank-2 drive flag |

## Verification
Output enables and transparent stages act within the same cycle as their inputs. The stored words change only at a rising clock edge. A word stored at edge N is therefore what a closed stage shows from edge N onward. The bench changes inputs 2 ns after each rising edge. It updates its reference stored words at the rising edge from the inputs that were stable up to that edge, and compares every output at the following falling edge. Each comparison therefore sees both the effects that are due in the same cycle and the words stored at the preceding edge.

// File: rtl/bl_pkg.sv
package bl_pkg;
    localparam int unsigned BL_W      = 12;
    localparam int unsigned BL_BANKS  = 2;

    typedef enum logic {
        PATH_BANK2 = 1'b0,
        PATH_BANK1 = 1'b1
    } path_sel_e;

    typedef enum logic [0:0] {
        BANK1 = 1'b0,
        BANK2 = 1'b1
    } bank_e;

    function automatic logic drive_of(input logic oe_n);
        return ~oe_n;
    endfunction
endpackage

// File: rtl/bl_stage.sv
module bl_stage #(
    parameter int unsigned W = bl_pkg::BL_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] held;

    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '0;
        end else if (en) begin
            held <= d;
        end
    end

    always_comb begin
        q = en ? d : held;
    end
endmodule

// File: rtl/bl_gate.sv
module bl_gate #(
    parameter int unsigned W = bl_pkg::BL_W
) (
    input  logic         oe_n,
    input  logic [W-1:0] val,
    output logic [W-1:0] dout,
    output logic         drive
);
    import bl_pkg::*;

    always_comb begin
        drive = drive_of(oe_n);
        dout  = drive ? val : '0;
    end
endmodule

// File: rtl/bl_b2a.sv
module bl_b2a #(
    parameter int unsigned W = bl_pkg::BL_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sel,
    input  logic         le1,
    input  logic         le2,
    input  logic         oe_n,
    input  logic [W-1:0] b1,
    input  logic [W-1:0] b2,
    output logic [W-1:0] dout,
    output logic         drive
);
    import bl_pkg::*;

    logic [W-1:0] q1, q2, picked;
    path_sel_e    path;

    bl_stage #(.W(W)) u_st1 (.clk(clk), .rst(rst), .en(le1), .d(b1), .q(q1));
    bl_stage #(.W(W)) u_st2 (.clk(clk), .rst(rst), .en(le2), .d(b2), .q(q2));

    always_comb begin
        path = path_sel_e'(sel);
        unique case (path)
            PATH_BANK1: picked = q1;
            PATH_BANK2: picked = q2;
            default:    picked = q2;
        endcase
    end

    bl_gate #(.W(W)) u_gate (.oe_n(oe_n), .val(picked), .dout(dout), .drive(drive));
endmodule

// File: rtl/bl_a2b.sv
module bl_a2b #(
    parameter int unsigned W     = bl_pkg::BL_W,
    parameter int unsigned BANKS = bl_pkg::BL_BANKS
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [W-1:0]            a,
    input  logic [BANKS-1:0]        le,
    input  logic [BANKS-1:0]        oe_n,
    output logic [BANKS-1:0][W-1:0] dout,
    output logic [BANKS-1:0]        drive
);
    for (genvar g = 0; g < BANKS; g++) begin : g_bank
        logic [W-1:0] q;
        bl_stage #(.W(W)) u_st (
            .clk(clk), .rst(rst), .en(le[g]), .d(a), .q(q)
        );
        bl_gate #(.W(W)) u_gate (
            .oe_n(oe_n[g]), .val(q), .dout(dout[g]), .drive(drive[g])
        );
    end
endmodule

// File: rtl/bl_mux_latch.sv
module bl_mux_latch #(
    parameter int unsigned W = bl_pkg::BL_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sel,
    input  logic         le_b1,
    input  logic         le_b2,
    input  logic         le_a1,
    input  logic         le_a2,
    input  logic         oe_a_n,
    input  logic         oe_b1_n,
    input  logic         oe_b2_n,
    input  logic [W-1:0] a_din,
    output logic [W-1:0] a_dout,
    output logic         a_drive,
    input  logic [W-1:0] b1_din,
    output logic [W-1:0] b1_dout,
    output logic         b1_drive,
    input  logic [W-1:0] b2_din,
    output logic [W-1:0] b2_dout,
    output logic         b2_drive
);
    import bl_pkg::*;

    localparam int unsigned NB = BL_BANKS;

    logic [NB-1:0][W-1:0] bank_dout;
    logic [NB-1:0]        bank_drive;

    bl_b2a #(.W(W)) u_b2a (
        .clk(clk), .rst(rst), .sel(sel), .le1(le_b1), .le2(le_b2),
        .oe_n(oe_a_n), .b1(b1_din), .b2(b2_din),
        .dout(a_dout), .drive(a_drive)
    );

    bl_a2b #(.W(W), .BANKS(NB)) u_a2b (
        .clk(clk), .rst(rst), .a(a_din),
        .le({le_a2, le_a1}), .oe_n({oe_b2_n, oe_b1_n}),
        .dout(bank_dout), .drive(bank_drive)
    );

    always_comb begin
        b1_dout  = bank_dout[BANK1];
        b1_drive = bank_drive[BANK1];
        b2_dout  = bank_dout[BANK2];
        b2_drive = bank_drive[BANK2];
    end
endmodule

// File: rtl/bl_mux_latch_chk.sv
module bl_mux_latch_chk #(
    parameter int unsigned W = bl_pkg::BL_W
) (
    input logic         clk,
    input logic         rst,
    input logic         sel,
    input logic         le_b1,
    input logic         le_a1,
    input logic         le_a2,
    input logic         oe_a_n,
    input logic         oe_b1_n,
    input logic         oe_b2_n,
    input logic [W-1:0] a_dout,
    input logic         a_drive,
    input logic [W-1:0] b1_din,
    input logic [W-1:0] b1_dout,
    input logic         b1_drive,
    input logic [W-1:0] b2_dout,
    input logic         b2_drive
);
    // R1: selected bank-1 stage open -> A follows live bank-1 input
    p_transparent_r1: assert property (@(posedge clk) disable iff (rst)
        (!oe_a_n && sel && le_b1) |-> (a_dout == b1_din));

    // R2: closed selected stage keeps A steady
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!oe_a_n && sel && !le_b1 && $past(!oe_a_n && sel && !le_b1 && !rst))
        |-> $stable(a_dout));

    // R4: closed bank-1 A-to-B stage is unaffected by the other bank
    p_bank_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!le_a1 && !oe_b1_n && $past(!le_a1 && !oe_b1_n && !rst))
        |-> $stable(b1_dout));

    // R5: disabled A port never drives
    p_a_off_r5: assert property (@(posedge clk) disable iff (rst)
        oe_a_n |-> (!a_drive && a_dout == '0));

    // R6: each bank enable gates only its own bank
    p_b1_off_r6: assert property (@(posedge clk) disable iff (rst)
        oe_b1_n |-> (!b1_drive && b1_dout == '0));
    p_b2_off_r6: assert property (@(posedge clk) disable iff (rst)
        oe_b2_n |-> (!b2_drive && b2_dout == '0));

    // R7: stage closed right after reset shows zero
    p_reset_r7: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && !le_a2 && !oe_b2_n) |-> (b2_dout == '0));
endmodule

bind bl_mux_latch bl_mux_latch_chk #(.W(W)) u_chk (
    .clk(clk), .rst(rst), .sel(sel), .le_b1(le_b1), .le_a1(le_a1),
    .le_a2(le_a2), .oe_a_n(oe_a_n), .oe_b1_n(oe_b1_n), .oe_b2_n(oe_b2_n),
    .a_dout(a_dout), .a_drive(a_drive), .b1_din(b1_din),
    .b1_dout(b1_dout), .b1_drive(b1_drive),
    .b2_dout(b2_dout), .b2_drive(b2_drive)
);

// File: tb/tb_bl_mux_latch.sv
`timescale 1ns/1ps
module tb_bl_mux_latch;
    localparam int W = 12;

    logic clk = 1'b0;
    logic rst, sel, le_b1, le_b2, le_a1, le_a2, oe_a_n, oe_b1_n, oe_b2_n;
    logic [W-1:0] a_din, b1_din, b2_din;
    logic [W-1:0] a_dout, b1_dout, b2_dout;
    logic a_drive, b1_drive, b2_drive;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 0;

    // reference stored words: 0 = B1->A, 1 = B2->A, 2 = A->B1, 3 = A->B2
    int ref_word [4];
    bit touched [4];

    always #5 clk = ~clk;

    bl_mux_latch #(.W(W)) dut (
        .clk(clk), .rst(rst), .sel(sel), .le_b1(le_b1), .le_b2(le_b2),
        .le_a1(le_a1), .le_a2(le_a2), .oe_a_n(oe_a_n), .oe_b1_n(oe_b1_n),
        .oe_b2_n(oe_b2_n), .a_din(a_din), .a_dout(a_dout), .a_drive(a_drive),
        .b1_din(b1_din), .b1_dout(b1_dout), .b1_drive(b1_drive),
        .b2_din(b2_din), .b2_dout(b2_dout), .b2_drive(b2_drive)
    );

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            for (int i = 0; i < 4; i++) begin
                ref_word[i] = 0;
                touched[i]  = 0;
            end
        end else begin
            if (le_b1) begin ref_word[0] = int'(b1_din); touched[0] = 1; end
            if (le_b2) begin ref_word[1] = int'(b2_din); touched[1] = 1; end
            if (le_a1) begin ref_word[2] = int'(a_din);  touched[2] = 1; end
            if (le_a2) begin ref_word[3] = int'(a_din);  touched[3] = 1; end
        end
    end

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", tag, what, act, exp, cycles);
        end
    endtask

    function automatic int stage_val(input bit en, input int live, input int idx);
        return en ? live : ref_word[idx];
    endfunction

    always @(negedge clk) begin
        if (!rst && !done) begin
            int ea, e1, e2;
            string ta, t1, t2;
            // A port
            if (oe_a_n) begin
                ea = 0; ta = "R5";
            end else if (sel) begin
                ea = stage_val(le_b1, int'(b1_din), 0);
                ta = le_b1 ? "R1" : (touched[0] ? "R2" : "R7");
            end else begin
                ea = stage_val(le_b2, int'(b2_din), 1);
                ta = le_b2 ? "R3" : (touched[1] ? "R3" : "R7");
            end
            check(ta, "a_dout", int'(a_dout), ea);
            check(oe_a_n ? "R5" : ta, "a_drive", int'(a_drive), oe_a_n ? 0 : 1);
            // bank 1
            e1 = oe_b1_n ? 0 : stage_val(le_a1, int'(a_din), 2);
            t1 = oe_b1_n ? "R6" : (touched[2] || le_a1 ? "R4" : "R7");
            check(t1, "b1_dout", int'(b1_dout), e1);
            check(t1, "b1_drive", int'(b1_drive), oe_b1_n ? 0 : 1);
            // bank 2
            e2 = oe_b2_n ? 0 : stage_val(le_a2, int'(a_din), 3);
            t2 = oe_b2_n ? "R6" : (touched[3] || le_a2 ? "R4" : "R7");
            check(t2, "b2_dout", int'(b2_dout), e2);
            check(t2, "b2_drive", int'(b2_drive), oe_b2_n ? 0 : 1);
        end
    end

    task automatic drive_in(input bit s, input bit lb1, input bit lb2, input bit la1,
                            input bit la2, input bit oa, input bit ob1, input bit ob2,
                            input int va, input int vb1, input int vb2);
        @(posedge clk); #2;
        sel = s; le_b1 = lb1; le_b2 = lb2; le_a1 = la1; le_a2 = la2;
        oe_a_n = oa; oe_b1_n = ob1; oe_b2_n = ob2;
        a_din = W'(va); b1_din = W'(vb1); b2_din = W'(vb2);
    endtask

    initial begin
        rst = 1; sel = 0; le_b1 = 1; le_b2 = 1; le_a1 = 1; le_a2 = 1;
        oe_a_n = 0; oe_b1_n = 0; oe_b2_n = 0;
        a_din = 12'hABC; b1_din = 12'h123; b2_din = 12'h456;
        repeat (3) @(posedge clk);
        #2;
        // R7: all stages closed after reset show zero
        rst = 0; le_b1 = 0; le_b2 = 0; le_a1 = 0; le_a2 = 0;
        drive_in(1, 0, 0, 0, 0, 0, 0, 0, 'h111, 'h222, 'h333);
        drive_in(0, 0, 0, 0, 0, 0, 0, 0, 'h444, 'h555, 'h666);
        // R1 transparency then R2 hold on bank-1 path
        drive_in(1, 1, 0, 0, 0, 0, 0, 0, 'h000, 'h7A5, 'h0F0);
        drive_in(1, 1, 0, 0, 0, 0, 0, 0, 'h000, 'h3C3, 'h0F0);
        drive_in(1, 0, 0, 0, 0, 0, 0, 0, 'h000, 'hFFF, 'h0F0);
        drive_in(1, 0, 0, 0, 0, 0, 0, 0, 'h000, 'h001, 'h0F0);
        // R3: bank-2 path stores while bank 1 selected, then switch
        drive_in(1, 0, 1, 0, 0, 0, 0, 0, 'h000, 'h002, 'h9E1);
        drive_in(0, 0, 0, 0, 0, 0, 0, 0, 'h000, 'h003, 'h004);
        drive_in(1, 0, 0, 0, 0, 0, 0, 0, 'h000, 'h005, 'h006);
        // R4: independent A-to-B stages
        drive_in(0, 0, 0, 1, 0, 0, 0, 0, 'h5A5, 'h0, 'h0);
        drive_in(0, 0, 0, 0, 1, 0, 0, 0, 'hA5A, 'h0, 'h0);
        drive_in(0, 0, 0, 0, 0, 0, 0, 0, 'h777, 'h0, 'h0);
        drive_in(0, 0, 0, 1, 0, 0, 0, 0, 'h888, 'h0, 'h0);
        // R5 / R6: every enable combination
        for (int k = 0; k < 8; k++)
            drive_in(k[0], 1, 1, 1, 1, k[0], k[1], k[2], 'h321 + k, 'h654, 'h987);
        // mixed patterns
        for (int n = 0; n < 400; n++) begin
            int r;
            r = int'($urandom);
            drive_in(r[0], r[1], r[2], r[3], r[4], (r[5] & r[6]), (r[7] & r[8]),
                     (r[9] & r[10]), int'($urandom) & 'hFFF,
                     int'($urandom) & 'hFFF, int'($urandom) & 'hFFF);
            if (n == 200) begin
                // R7: reset mid-run
                @(posedge clk); #2; rst = 1;
                @(posedge clk); #2; rst = 0; le_b1 = 0; le_b2 = 0; le_a1 = 0; le_a2 = 0;
            end
        end
        @(posedge clk); @(negedge clk); #1;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule